// File: doc/BRIEF.md
# Serial wire debug target acknowledge and sticky status logic

This block sits on the target side of a two-wire serial debug link, behind the wire-level shifter. The shifter hands it one strobe for each packet request whose start, stop, park and parity bits were accepted. The strobe comes with the port-select bit, the read/not-write bit and the two address bits. From these and from the busy state of the access port, the block chooses the three-bit acknowledge the target sends back. It also tells the shifter whether a 32-bit data phase follows, and whether the target itself drives that phase.

The block holds the overrun-detect enable and four sticky flags. The flags record an overrun, an access-port error, a compare match and a write-data parity error. Any flag that is set makes ordinary requests fail with FAULT. Only a write to the abort register clears the flags, and a single abort write may clear several of them. Three requests bypass WAIT and FAULT altogether, so a debugger can always read the identity and status registers and can always recover through the abort register.

Top module: `swd_resp_ctrl`

## Requirements
- R1: A debug-port request (port bit 0) that is a read at address 0 or 1, or a write at address 0, always gets OK, whatever the busy inputs and the sticky flags are.
- R2: Any other request gets FAULT when at least one sticky flag is set at the time of the request.
- R3: Any other request with all flags clear gets WAIT when the port is busy, or when it is an access-port read while the previous read result is still pending.
- R4: Otherwise the acknowledge is OK. The acknowledge appears one cycle after the request strobe, together with a one-cycle valid pulse. The codes are OK=3'b001, WAIT=3'b010 and FAULT=3'b100, and the acknowledge reads 3'b000 in cycles with no request.
- R5: When overrun detection is enabled at the time of a request that gets WAIT or FAULT, the sticky overrun flag is set in the same cycle as the acknowledge.
- R6: The data-phase flag is 1 for every OK, and for WAIT or FAULT only when overrun detection was enabled at the request. The read-drive flag is 1 only for an OK to a read.
- R7: A write-data parity error strobe sets the write-data-error flag. If overrun detection is enabled, it also sets the overrun flag.
- R8: In an abort write, bit 1 clears the compare flag, bit 2 the error flag, bit 3 the write-data-error flag and bit 4 the overrun flag, and several of these may be cleared at once. A set event in the same cycle takes precedence over a clear.
- R9: After reset all flags, the overrun enable and the acknowledge outputs are 0. A control write loads only the overrun enable and leaves every sticky flag unchanged.
- R10: The access-port error strobe sets the error flag and the compare strobe sets the compare flag. The flag vector is ordered as bit 0 overrun, bit 1 compare, bit 2 error, bit 3 write-data error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | One-cycle strobe for a valid decoded packet request |
| req_ap_i | input | 1 | 1 = access-port request, 0 = debug-port request |
| req_rd_i | input | 1 | 1 = read, 0 = write |
| req_addr_i | input | 2 | Register address bits of the request |
| ap_busy_i | input | 1 | A previous access is still outstanding |
| ap_rd_pending_i | input | 1 | The previous access-port read result is not yet available |
| wdata_perr_i | input | 1 | Strobe: write-data parity mismatch |
| err_event_i | input | 1 | Strobe: access-port error |
| cmp_event_i | input | 1 | Strobe: compare match |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_orun_en_i | input | 1 | Overrun-detect enable value written by a control write |
| abort_wr_i | input | 1 | Abort register write strobe |
| abort_wdata_i | input | 4 | Abort write data bits 4 down to 1 |
| ack_valid_o | output | 1 | Acknowledge valid pulse |
| ack_o | output | 3 | Acknowledge code |
| data_phase_o | output | 1 | A data phase follows this acknowledge |
| drive_rdata_o | output | 1 | The target drives read data in the data phase |
| orun_en_o | output | 1 | Overrun detection enabled |
| sticky_o | output | 4 | Sticky flags: overrun, compare, error, write-data error |

## Verification
The assertions assume that the request strobe only ever reports headers the shifter has already accepted, and that busy, pending and event inputs are stable single-cycle levels sampled at the clock edge. Every input is driven away from the edge and held for a whole cycle, so this holds in the bench. The random part keeps the strobes for errors and compare events rare and issues abort writes often. As a result the flags are set and cleared repeatedly, and OK, WAIT and FAULT all occur with overrun detection both on and off. Directed cases cover a set event and a clear of the same flag in one cycle, and clearing several flags in one abort write.

// File: rtl/swd_resp_pkg.sv
package swd_resp_pkg;

  typedef enum logic [2:0] {
    ACK_NONE  = 3'b000,
    ACK_OK    = 3'b001,
    ACK_WAIT  = 3'b010,
    ACK_FAULT = 3'b100
  } ack_e;

  localparam int ADDR_W    = 2;
  localparam int NUM_FLAGS = 4;

  // flag vector positions
  localparam int F_ORUN = 0;
  localparam int F_CMP  = 1;
  localparam int F_ERR  = 2;
  localparam int F_WDE  = 3;

  // abort register clear-bit positions (decoded by software)
  localparam int ABT_LO   = 1;
  localparam int ABT_HI   = 4;
  localparam int ABT_CMP  = 1;
  localparam int ABT_ERR  = 2;
  localparam int ABT_WDE  = 3;
  localparam int ABT_ORUN = 4;

  // which abort bit clears a given flag
  function automatic int clr_pos(input int flag);
    case (flag)
      F_ORUN:  return ABT_ORUN;
      F_CMP:   return ABT_CMP;
      F_ERR:   return ABT_ERR;
      default: return ABT_WDE;
    endcase
  endfunction

  // requests that bypass WAIT and FAULT: id read, status read, abort write
  function automatic logic req_exempt(input logic ap, input logic rd,
                                      input logic [ADDR_W-1:0] addr);
    if (ap) return 1'b0;
    if (rd) return (addr[1] == 1'b0);
    return (addr == '0);
  endfunction

  // priority: exemption, then sticky fault, then stall, else OK
  function automatic ack_e pick_ack(input logic exempt, input logic any_sticky,
                                    input logic stall);
    if (exempt)     return ACK_OK;
    if (any_sticky) return ACK_FAULT;
    if (stall)      return ACK_WAIT;
    return ACK_OK;
  endfunction

endpackage

// File: rtl/swd_req_classify.sv
module swd_req_classify
  import swd_resp_pkg::*;
(
  input  logic              req_ap_i,
  input  logic              req_rd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              ap_busy_i,
  input  logic              ap_rd_pending_i,
  output logic              exempt_o,
  output logic              stall_o
);

  assign exempt_o = req_exempt(req_ap_i, req_rd_i, req_addr_i);
  // an access-port read must also wait for the previous read result
  assign stall_o  = ap_busy_i | (req_ap_i & req_rd_i & ap_rd_pending_i);

  always_comb begin
    if (exempt_o) a_r1_exempt_is_dp : assert (!req_ap_i);
  end

endmodule

// File: rtl/swd_ack_select.sv
module swd_ack_select
  import swd_resp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid_i,
  input  logic       req_rd_i,
  input  logic       exempt_i,
  input  logic       stall_i,
  input  logic       any_sticky_i,
  input  logic       orun_en_i,
  output logic       nonok_o,
  output logic       ack_valid_o,
  output logic [2:0] ack_o,
  output logic       data_phase_o,
  output logic       drive_rdata_o
);

  ack_e decision;
  ack_e ack_q;

  always_comb decision = pick_ack(exempt_i, any_sticky_i, stall_i);

  // named event: a request answered with WAIT or FAULT in this cycle
  assign nonok_o = req_valid_i && (decision != ACK_OK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid_o   <= 1'b0;
      ack_q         <= ACK_NONE;
      data_phase_o  <= 1'b0;
      drive_rdata_o <= 1'b0;
    end else begin
      ack_valid_o   <= req_valid_i;
      ack_q         <= req_valid_i ? decision : ACK_NONE;
      data_phase_o  <= req_valid_i && ((decision == ACK_OK) || orun_en_i);
      drive_rdata_o <= req_valid_i && (decision == ACK_OK) && req_rd_i;
    end
  end

  assign ack_o = ack_q;

  a_r1_exempt_ok : assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i && exempt_i |=> ack_o == ACK_OK);

  a_r2_fault_on_sticky : assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i && !exempt_i && any_sticky_i |=> ack_o == ACK_FAULT);

  a_r3_wait_on_stall : assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i && !exempt_i && !any_sticky_i && stall_i |=> ack_o == ACK_WAIT);

  a_r4_onehot_ack : assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid_o |-> $countones(ack_o) == 1);

  a_r4_quiet_ack : assert property (@(posedge clk) disable iff (!rst_n)
    !ack_valid_o |-> ack_o == ACK_NONE && !data_phase_o);

  a_r6_ok_has_data : assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid_o && ack_o == ACK_OK |-> data_phase_o);

  a_r6_drive_only_ok : assert property (@(posedge clk) disable iff (!rst_n)
    drive_rdata_o |-> ack_o == ACK_OK);

  a_r6_nonok_phase : assert property (@(posedge clk) disable iff (!rst_n)
    nonok_o |=> data_phase_o == $past(orun_en_i));

endmodule

// File: rtl/swd_sticky_bank.sv
module swd_sticky_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flags_o[i] <= 1'b0;
      else if (set_i[i])  flags_o[i] <= 1'b1;   // set beats clear
      else if (clr_i[i])  flags_o[i] <= 1'b0;
    end

    a_r8_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flags_o[i]);

    a_r8_clear_works : assert property (@(posedge clk) disable iff (!rst_n)
      clr_i[i] && !set_i[i] |=> !flags_o[i]);

    a_r8_sticky_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i[i] && flags_o[i] |=> flags_o[i]);

    a_r8_no_spurious : assert property (@(posedge clk) disable iff (!rst_n)
      !set_i[i] && !flags_o[i] |=> !flags_o[i]);
  end

endmodule

// File: rtl/swd_resp_ctrl.sv
module swd_resp_ctrl
  import swd_resp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid_i,
  input  logic                req_ap_i,
  input  logic                req_rd_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic                ap_busy_i,
  input  logic                ap_rd_pending_i,
  input  logic                wdata_perr_i,
  input  logic                err_event_i,
  input  logic                cmp_event_i,
  input  logic                ctrl_wr_i,
  input  logic                ctrl_orun_en_i,
  input  logic                abort_wr_i,
  input  logic [ABT_HI:ABT_LO] abort_wdata_i,
  output logic                ack_valid_o,
  output logic [2:0]          ack_o,
  output logic                data_phase_o,
  output logic                drive_rdata_o,
  output logic                orun_en_o,
  output logic [NUM_FLAGS-1:0] sticky_o
);

  logic                 exempt, stall, nonok, any_sticky, orun_en_q;
  logic [NUM_FLAGS-1:0] flag_set, flag_clr;

  assign any_sticky = |sticky_o;
  assign orun_en_o  = orun_en_q;

  // control write touches only the overrun enable; sticky bits ignore it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         orun_en_q <= 1'b0;
    else if (ctrl_wr_i) orun_en_q <= ctrl_orun_en_i;
  end

  swd_req_classify i_classify (
    .req_ap_i        (req_ap_i),
    .req_rd_i        (req_rd_i),
    .req_addr_i      (req_addr_i),
    .ap_busy_i       (ap_busy_i),
    .ap_rd_pending_i (ap_rd_pending_i),
    .exempt_o        (exempt),
    .stall_o         (stall)
  );

  swd_ack_select i_ack (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid_i   (req_valid_i),
    .req_rd_i      (req_rd_i),
    .exempt_i      (exempt),
    .stall_i       (stall),
    .any_sticky_i  (any_sticky),
    .orun_en_i     (orun_en_q),
    .nonok_o       (nonok),
    .ack_valid_o   (ack_valid_o),
    .ack_o         (ack_o),
    .data_phase_o  (data_phase_o),
    .drive_rdata_o (drive_rdata_o)
  );

  // set sources per flag
  always_comb begin
    flag_set         = '0;
    flag_set[F_ORUN] = orun_en_q & (nonok | wdata_perr_i);
    flag_set[F_CMP]  = cmp_event_i;
    flag_set[F_ERR]  = err_event_i;
    flag_set[F_WDE]  = wdata_perr_i;
  end

  // clear sources: one abort bit per flag
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_clr
    assign flag_clr[i] = abort_wr_i & abort_wdata_i[clr_pos(i)];
  end

  swd_sticky_bank #(.N(NUM_FLAGS)) i_sticky (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (flag_set),
    .clr_i   (flag_clr),
    .flags_o (sticky_o)
  );

  a_r5_orun_on_nonok : assert property (@(posedge clk) disable iff (!rst_n)
    nonok && orun_en_q |=> sticky_o[F_ORUN]);

  a_r5_no_orun_when_off : assert property (@(posedge clk) disable iff (!rst_n)
    !orun_en_q && !sticky_o[F_ORUN] |=> !sticky_o[F_ORUN]);

  a_r7_perr_sets_wde : assert property (@(posedge clk) disable iff (!rst_n)
    wdata_perr_i |=> sticky_o[F_WDE]);

  a_r9_enable_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr_i |=> $stable(orun_en_o));

  a_r10_err_sets : assert property (@(posedge clk) disable iff (!rst_n)
    err_event_i |=> sticky_o[F_ERR]);

endmodule

// File: tb/test_swd_resp_ctrl.sv
module test_swd_resp_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       req_valid, req_ap, req_rd, busy, pend, perr, errev, cmpev;
  logic       ctrl_wr, ctrl_en, abort_wr;
  logic [1:0] addr;
  logic [4:1] abort_d;
  logic       ack_valid, data_phase, drive_rdata, orun_en;
  logic [2:0] ack;
  logic [3:0] sticky;

  swd_resp_ctrl i_swd_resp_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ap_i(req_ap),
    .req_rd_i(req_rd), .req_addr_i(addr), .ap_busy_i(busy),
    .ap_rd_pending_i(pend), .wdata_perr_i(perr), .err_event_i(errev),
    .cmp_event_i(cmpev), .ctrl_wr_i(ctrl_wr), .ctrl_orun_en_i(ctrl_en),
    .abort_wr_i(abort_wr), .abort_wdata_i(abort_d), .ack_valid_o(ack_valid),
    .ack_o(ack), .data_phase_o(data_phase), .drive_rdata_o(drive_rdata),
    .orun_en_o(orun_en), .sticky_o(sticky)
  );

  int errors = 0;
  int checks = 0;

  // reference state: flags [0]=overrun [1]=compare [2]=error [3]=wdata error
  logic [3:0] m_flags = '0;
  logic       m_en = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 0; req_ap = 0; req_rd = 0; addr = 0; busy = 0; pend = 0;
    perr = 0; errev = 0; cmpev = 0; ctrl_wr = 0; ctrl_en = 0;
    abort_wr = 0; abort_d = 0;
  endtask

  // the expected acknowledge and the requirement it comes from
  function automatic logic [2:0] model_ack(output string tag);
    logic free_pass;
    free_pass = (req_ap == 0) &&
                ((req_rd == 1 && addr <= 2'd1) || (req_rd == 0 && addr == 2'd0));
    if (free_pass)                        begin tag = "R1"; return 3'b001; end
    if (m_flags != 0)                     begin tag = "R2"; return 3'b100; end
    if (busy || (req_ap && req_rd && pend)) begin tag = "R3"; return 3'b010; end
    tag = "R4";
    return 3'b001;
  endfunction

  // one clock: predict, clock, sample away from the edge, update the model
  task automatic tick();
    string      atag, ftag;
    logic [2:0] e_ack;
    logic       e_dp, e_drv;
    logic [3:0] set_v, clr_v, nxt;
    e_ack = req_valid ? model_ack(atag) : 3'b000;
    if (!req_valid) atag = "R4";
    e_dp  = req_valid && (e_ack == 3'b001 || m_en);
    e_drv = req_valid && e_ack == 3'b001 && req_rd;
    set_v[0] = m_en && ((req_valid && e_ack != 3'b001) || perr);
    set_v[1] = cmpev;
    set_v[2] = errev;
    set_v[3] = perr;
    clr_v = abort_wr ? {abort_d[3], abort_d[2], abort_d[1], abort_d[4]} : 4'b0;
    nxt = set_v | (m_flags & ~clr_v);
    @(posedge clk);
    #2;
    check("R4 valid", int'(ack_valid), int'(req_valid));
    check(atag, int'(ack), int'(e_ack));
    check("R6 data phase", int'(data_phase), int'(e_dp));
    check("R6 read drive", int'(drive_rdata), int'(e_drv));
    ftag = abort_wr ? "R8 flags" : (perr ? "R7 flags" : "R5/R10 flags");
    check(ftag, int'(sticky), int'(nxt));
    m_flags = nxt;
    if (ctrl_wr) m_en = ctrl_en;
    check("R9 enable", int'(orun_en), int'(m_en));
    idle();
  endtask

  task automatic req(input logic ap, input logic rd, input logic [1:0] a);
    req_valid = 1; req_ap = ap; req_rd = rd; addr = a;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    repeat (3) @(posedge clk);
    #2;
    // R9 reset state
    check("R9 reset flags", int'(sticky), 0);
    check("R9 reset enable", int'(orun_en), 0);
    check("R9 reset ack", int'({ack_valid, ack, data_phase}), 0);
    rst_n = 1;
    tick();

    // R3 with detection off: WAIT, no data phase, no overrun flag (R5, R6)
    req(1, 0, 2'd1); busy = 1; tick();
    // R3 AP read while previous read pending
    req(1, 1, 2'd2); pend = 1; tick();
    // pending only matters for AP reads: R4
    req(1, 0, 2'd2); pend = 1; tick();
    // enable detection
    ctrl_wr = 1; ctrl_en = 1; tick();
    // R5: WAIT sets overrun, R6 data phase present
    req(1, 0, 2'd3); busy = 1; tick();
    // R1 status read while busy and flagged
    req(0, 1, 2'd1); busy = 1; tick();
    // R1 id read, abort write
    req(0, 1, 2'd0); busy = 1; tick();
    req(0, 0, 2'd0); busy = 1; tick();
    // R2 fault afterwards, data phase because detection on
    req(1, 1, 2'd0); tick();
    req(0, 0, 2'd2); tick();
    // R9 control write leaves flags untouched
    ctrl_wr = 1; ctrl_en = 1; tick();
    // R8 clear overrun by bit 4
    abort_wr = 1; abort_d = 4'b1000; tick();
    // R7 parity error sets write-data error and overrun
    perr = 1; tick();
    // R8 clear both in one write
    abort_wr = 1; abort_d = 4'b1100; tick();
    // R10 error event with simultaneous clear: set wins (R8)
    errev = 1; abort_wr = 1; abort_d = 4'b0010; tick();
    abort_wr = 1; abort_d = 4'b0010; tick();
    // R10 compare event, cleared by bit 1
    cmpev = 1; tick();
    abort_wr = 1; abort_d = 4'b0001; tick();
    // detection off, fault without overrun
    cmpev = 1; ctrl_wr = 1; ctrl_en = 0; tick();
    req(1, 0, 2'd0); tick();
    abort_wr = 1; abort_d = 4'b1111; tick();

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      req_valid = ($urandom % 10) < 6;
      req_ap    = $urandom % 2;
      req_rd    = $urandom % 2;
      addr      = 2'($urandom % 4);
      busy      = ($urandom % 4) == 0;
      pend      = ($urandom % 3) == 0;
      perr      = ($urandom % 30) == 0;
      errev     = ($urandom % 30) == 0;
      cmpev     = ($urandom % 30) == 0;
      ctrl_wr   = ($urandom % 20) == 0;
      ctrl_en   = $urandom % 2;
      abort_wr  = ($urandom % 6) == 0;
      abort_d   = 4'($urandom % 16);
      tick();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule